// File: doc/BRIEF.md
# Single-Cycle Four-Instruction Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It supports four operations: register add, word load, word store and branch-if-equal. In the same cycle the core fetches an instruction from a combinational instruction port and reads two operands from a 32-entry register file. It then forms a sum in the main adder, reads or writes a data port, and selects the next program counter. Only the program counter, the register file and the external data memory change state, and they change at the clock edge.

Both memories are external. The instruction port and the data read port are combinational: the address goes out and the word comes back in the same cycle. A data write is taken by the memory on the rising clock edge whenever the write strobe is high. Two adders separate from the main adder produce the sequential address and the branch target. The branch displacement is scaled by four through wiring only.

Instruction fields: opcode in bits 31:26, first source register in 25:21, second source/target register in 20:16, destination register in 15:11, function code in 5:0, and a 16-bit signed immediate in 15:0.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and dmem_we_o is 0. The first instruction after release is fetched from address 0.
- R2: For every opcode other than 0x04, the next fetch address is the current one plus 4. Fetch addresses are always word aligned.
- R3: Opcode 0x00 with function code 0x20 writes the 32-bit wrapping sum of registers [25:21] and [20:16] into register [15:11].
- R4: Opcode 0x23 loads into register [20:16] the data word at register [25:21] plus the sign-extended 16-bit immediate.
- R5: Opcode 0x2B presents register [20:16] on dmem_wdata_o at address register [25:21] plus the sign-extended immediate, with dmem_we_o high. dmem_we_o is high for no other opcode.
- R6: Opcode 0x04 with equal registers [25:21] and [20:16] sets the next fetch address to current+4 plus the sign-extended immediate times 4, negative values included. With unequal registers the next fetch address is current+4.
- R7: Register 0 always reads as zero. Add and load writes aimed at it are discarded.
- R8: Any other opcode, and opcode 0x00 with a function code other than 0x20, writes no register and no memory and only advances the fetch address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction fetch address (program counter) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data byte address from the main adder |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, taken at the rising clock edge |
| dmem_rdata_i | input | 32 | Data word at dmem_addr_o, same cycle |

## Verification
The bench targets branch arithmetic. It takes a forward branch over two stores, follows it with a not-taken branch, and ends on a branch to itself with offset -1. If the core dropped the scaling by four or the sign extension, it would land on one of the skipped stores or run off the loop. Negative load and store offsets around a non-zero base are used to expose a zero-extending immediate. An add that wraps past 2^32 is also tested. Writes aimed at register 0 and a set of undefined encodings are each followed by a store of the target register, so that a core which wrongly updated the register file leaves a visibly different word in data memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef struct packed {
    logic rf_we;       // register write
    logic wb_from_mem; // write-back source: data port
    logic dst_is_rd;   // destination field [15:11] vs [20:16]
    logic b_is_imm;    // adder operand B: immediate
    logic mem_we;      // store
    logic branch;      // conditional branch
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (op_i)
      OP_RTYPE: if (funct_i == FN_ADD) begin
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.dst_is_rd = 1'b1;
      end
      OP_LW: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.wb_from_mem = 1'b1;
        ctrl_o.b_is_imm    = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_we   = 1'b1;
        ctrl_o.b_is_imm = 1'b1;
      end
      OP_BEQ: ctrl_o.branch = 1'b1;
      default: ctrl_o = '0; // undefined: no-op
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic [AW-1:0]   ra_a_i,
  input  logic [AW-1:0]   ra_b_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i) begin
        if (we_i && wa_i == AW'(g)) regs[g] <= wd_i;
      end
    end
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];
endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit #(
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [15:0]     disp_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q, seq_pc, tgt_pc, disp_x4;

  // scale by 4 through wiring
  assign disp_x4 = {{(XLEN-18){disp_i[15]}}, disp_i, 2'b00};
  assign seq_pc  = pc_q + XLEN'(4);
  assign tgt_pc  = seq_pc + disp_x4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_ADDR[XLEN-1:0];
    else         pc_q <= take_i ? tgt_pc : seq_pc;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int unsigned AW = $clog2(NREG);

  ctrl_t           ctrl;
  logic [AW-1:0]   rs_idx, rt_idx, rd_idx, wa;
  logic [XLEN-1:0] rs_data, rt_data, imm_ext, opnd_b, sum, wb_data;
  logic            rf_we, take;

  assign rs_idx = imem_data_i[21+AW-1:21];
  assign rt_idx = imem_data_i[16+AW-1:16];
  assign rd_idx = imem_data_i[11+AW-1:11];

  sc_decode u_dec (
    .op_i    (imem_data_i[31:26]),
    .funct_i (imem_data_i[5:0]),
    .ctrl_o  (ctrl)
  );

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .ra_a_i (rs_idx),
    .ra_b_i (rt_idx),
    .rd_a_o (rs_data),
    .rd_b_o (rt_data),
    .we_i   (rf_we),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  // main adder
  assign imm_ext = {{(XLEN-16){imem_data_i[15]}}, imem_data_i[15:0]};
  assign opnd_b  = ctrl.b_is_imm ? imm_ext : rt_data;
  assign sum     = rs_data + opnd_b;

  assign wa      = ctrl.dst_is_rd ? rd_idx : rt_idx;
  assign wb_data = ctrl.wb_from_mem ? dmem_rdata_i : sum;
  assign rf_we   = ctrl.rf_we & rst_ni;

  assign take = ctrl.branch & (rs_data == rt_data);

  sc_pc_unit #(.XLEN(XLEN)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .disp_i (imem_data_i[15:0]),
    .pc_o   (imem_addr_o)
  );

  assign dmem_addr_o  = sum;
  assign dmem_wdata_o = rt_data;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] rs_data_i,
  input logic [XLEN-1:0] rt_data_i,
  input logic            rf_we_i,
  input logic            dmem_we_i
);
  logic [5:0]      op;
  logic [XLEN-1:0] br_step;
  assign op      = instr_i[31:26];
  assign br_step = XLEN'(4) + {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};

  AST_RESET_HOLD: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_i == '0 && !dmem_we_i)); // R1
  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i[1:0] == 2'b00); // R2
  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ) |=> (pc_i == $past(pc_i) + XLEN'(4))); // R2
  AST_BR_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i == rt_data_i) |=> (pc_i == $past(pc_i) + $past(br_step))); // R6
  AST_BR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i != rt_data_i) |=> (pc_i == $past(pc_i) + XLEN'(4))); // R6
  AST_STORE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_i |-> (op == OP_SW)); // R5
  AST_R0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[25:21] == 5'd0) |-> (rs_data_i == '0)); // R7
  AST_RF_WE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> (op == OP_LW || (op == OP_RTYPE && instr_i[5:0] == FN_ADD))); // R8
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_i      (imem_addr_o),
  .instr_i   (imem_data_i),
  .rs_data_i (rs_data),
  .rt_data_i (rt_data),
  .rf_we_i   (rf_we),
  .dmem_we_i (dmem_we_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [MW];
  logic [31:0] dmem [MW];
  int          n_checks = 0;
  int          n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_rdata_i (dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_add(input logic [4:0] rd, rs, rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] enc_r(input logic [4:0] rd, rs, rt, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_ni = 1'b0;
    for (int i = 0; i < MW; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    imem[0] = enc_i(6'h2B, 5'd0, 5'd0, 16'd0); // store at 0 must not fire in reset
    imem[1] = 32'h0;
    imem[2] = 32'h0;
    dmem[0] = 32'h5A5A_0001;
    @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'h0);
    check("R1 no store in reset", {31'd0, dmem_we}, 32'h0);
    @(negedge clk);
    check("R1 mem untouched", dmem[0], 32'h5A5A_0001);
    rst_ni = 1'b1;
    check("R1 first fetch", imem_addr, 32'h0);
    run(3);
    check("R2 sequential fetch", imem_addr, 32'd12);
  endtask

  task automatic t_add_load_store();
    hold_reset();
    dmem[0] = 32'd5;
    dmem[1] = 32'd7;
    dmem[3] = 32'hFFFF_FFFF;
    imem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    imem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    imem[2] = enc_add(5'd3, 5'd1, 5'd2);
    imem[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'd8);
    imem[4] = enc_i(6'h23, 5'd0, 5'd4, 16'd12);
    imem[5] = enc_add(5'd5, 5'd4, 5'd2);
    imem[6] = enc_i(6'h2B, 5'd0, 5'd5, 16'd16);
    release_reset();
    run(3);
    check("R5 store strobe on sw", {31'd0, dmem_we}, 32'd1);
    check("R5 store address", dmem_addr, 32'd8);
    run(4);
    check("R3 add sum", dmem[2], 32'd12);
    check("R3 add wraps", dmem[4], 32'd6);
    check("R2 pc after 7", imem_addr, 32'd28);
  endtask

  task automatic t_neg_offset();
    hold_reset();
    dmem[0]  = 32'hC0FF_EE00;
    dmem[5]  = 32'h80;
    dmem[31] = 32'h0000_A5A5;
    imem[0] = enc_i(6'h23, 5'd0, 5'd6, 16'd20);
    imem[1] = enc_i(6'h23, 5'd0, 5'd7, 16'd0);
    imem[2] = enc_i(6'h2B, 5'd6, 5'd7, 16'hFFF8);  // 0x80-8 -> word 30
    imem[3] = enc_i(6'h23, 5'd6, 5'd8, 16'hFFFC);  // 0x80-4 -> word 31
    imem[4] = enc_i(6'h2B, 5'd0, 5'd8, 16'd24);
    release_reset();
    run(5);
    check("R5 store negative offset", dmem[30], 32'hC0FF_EE00);
    check("R4 load negative offset", dmem[6], 32'h0000_A5A5);
  endtask

  task automatic t_branch();
    hold_reset();
    dmem[0] = 32'd9;
    dmem[1] = 32'd9;
    dmem[2] = 32'd3;
    imem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    imem[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    imem[2] = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
    imem[3] = enc_i(6'h04, 5'd1, 5'd2, 16'd2);     // 12 -> 24
    imem[4] = enc_i(6'h2B, 5'd0, 5'd1, 16'd40);
    imem[5] = enc_i(6'h2B, 5'd0, 5'd1, 16'd44);
    imem[6] = enc_i(6'h04, 5'd1, 5'd3, 16'd1);     // not taken
    imem[7] = enc_i(6'h2B, 5'd0, 5'd3, 16'd48);
    imem[8] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);  // self loop
    release_reset();
    run(4);
    check("R6 taken target", imem_addr, 32'd24);
    run(1);
    check("R6 not taken", imem_addr, 32'd28);
    run(1);
    check("R6 reach loop", imem_addr, 32'd32);
    run(3);
    check("R6 backward self loop", imem_addr, 32'd32);
    check("R6 skipped store a", dmem[10], 32'h0);
    check("R6 skipped store b", dmem[11], 32'h0);
    check("R6 fallthrough store", dmem[12], 32'd3);
  endtask

  task automatic t_reg_zero();
    hold_reset();
    dmem[0]  = 32'd11;
    dmem[13] = 32'hDEAD_0000;
    imem[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    imem[1] = enc_add(5'd0, 5'd1, 5'd1);
    imem[2] = enc_i(6'h23, 5'd0, 5'd0, 16'd0);
    imem[3] = enc_i(6'h2B, 5'd0, 5'd0, 16'd52);
    imem[4] = enc_add(5'd9, 5'd0, 5'd1);
    imem[5] = enc_i(6'h2B, 5'd0, 5'd9, 16'd56);
    release_reset();
    run(6);
    check("R7 r0 stays zero", dmem[13], 32'h0);
    check("R7 r0 as operand", dmem[14], 32'd11);
  endtask

  task automatic t_undefined();
    hold_reset();
    dmem[0] = 32'h0000_1234;
    imem[0] = enc_i(6'h23, 5'd0, 5'd5, 16'd0);
    imem[1] = enc_i(6'h08, 5'd0, 5'd5, 16'd7);
    imem[2] = enc_r(5'd5, 5'd5, 5'd5, 6'h22);
    imem[3] = enc_i(6'h0F, 5'd0, 5'd5, 16'h7777);
    imem[4] = enc_i(6'h2A, 5'd0, 5'd5, 16'd60);
    imem[5] = enc_i(6'h2B, 5'd0, 5'd5, 16'd60);
    release_reset();
    run(1);
    check("R8 no store on undefined op", {31'd0, dmem_we}, 32'h0);
    run(3);
    check("R8 no store on near-sw op", {31'd0, dmem_we}, 32'h0);
    check("R8 pc advances", imem_addr, 32'd16);
    run(2);
    check("R8 register unchanged", dmem[15], 32'h0000_1234);
  endtask

  initial begin
    t_reset();
    t_add_load_store();
    t_neg_offset();
    t_branch();
    t_reg_zero();
    t_undefined();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule